// File: doc/BRIEF.md
# UART Line Status Tracker

This block holds the line status word of a UART that has receive and transmit FIFOs. The receive datapath reports each character it delivers with three tag bits (parity error, framing error, break). The tracker keeps a tag shadow of the receive FIFO so that every stored character carries its own tags. When a character is popped, its tags are turned into sticky indicators that the CPU sees. An aggregate flag stays up while any tagged character is still stored. It is dropped by a status read only once none remain.

On the transmit side the block tracks the transmit FIFO fill level and the shift-register idle signal. From these it derives the holding-register-empty and transmitter-empty flags. It also drives an interrupt from holding-register-empty, gated by an enable. A break detector watches the receive line. It counts bit-time ticks while the line is low and compares the count with the frame length given by the word length, parity and stop-bit configuration. The status word is 32 bits, of which only the low byte is used.

All inputs are synchronous to `clk`, including `rx_line`. Status bits are registered and clear one cycle after a read strobe.

Top module: `uart_line_status`

## Requirements
- R1: After reset, status reads 0x00000060: transmitter empty (bit 6) and holding-register empty (bit 5) are 1, and every other bit is 0.
- R2: Bit 0 (data ready) is 1 exactly when the receive FIFO holds at least one character.
- R3: A character strobe arriving while the receive FIFO holds RX_DEPTH entries is dropped and sets bit 1 (overrun) until a status read.
- R4: Popping a character whose tag has parity, framing or break set raises bit 2, bit 3 or bit 4 respectively. The bit stays set until a status read.
- R5: Bit 7 is 1 whenever a tagged character is stored. A status read clears it only if no tagged character remains after that cycle.
- R6: With the line low, bit 4 sets on the tick after frame_bits ticks have passed, where frame_bits = 1 + (5 + word_len_code) + parity_en + (1 + two_stop). Sticky bit 4 is raised only once per low period.
- R7: A status read clears bits 1 to 4 in the following cycle, except when a set event for the same bit occurs in the read cycle, which wins.
- R8: Bit 5 is 1 exactly when the transmit FIFO is empty. A write clears it and the transfer of the last word sets it.
- R9: Bit 6 is 1 only when the transmit FIFO is empty and the shift register reports idle.
- R10: thre_irq equals bit 5 while thre_irq_en is 1 and is 0 while thre_irq_en is 0.
- R11: Bits 31 to 8 of status always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char_valid | input | 1 | Received-character strobe |
| rx_tag_par | input | 1 | Parity-error tag of the strobed character |
| rx_tag_frm | input | 1 | Framing-error tag of the strobed character |
| rx_tag_brk | input | 1 | Break tag of the strobed character |
| rx_pop | input | 1 | CPU reads one character from the receive FIFO |
| tx_push | input | 1 | CPU writes one word into the transmit FIFO |
| tx_pop | input | 1 | Transmit FIFO head moves into the shift register |
| tsr_idle | input | 1 | Transmit shift register is empty |
| rx_line | input | 1 | Receive line level |
| baud_tick | input | 1 | One pulse per bit time |
| cfg_word_len | input | 2 | Word length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_two_stop | input | 1 | Two stop bits |
| thre_irq_en | input | 1 | Interrupt enable for holding-register empty |
| stat_rd | input | 1 | Status register read strobe |
| status | output | 32 | Line status word |
| thre_irq | output | 1 | Holding-register-empty interrupt |

## Verification
Assertions check on every cycle that the tagged-entry count never exceeds the stored-entry count and that a stored tag always shows in bit 7. They also check that a dropped character leaves the fill level unchanged, that transmitter empty implies holding empty, that a write clears holding empty, that a break fires for a single cycle, and that sticky bits hold until a read. Only the bench scenarios can show the exact values of the status word: the overrun at the depth limit, the order in which tags appear as characters are popped, a read colliding with a pop or push, and the exact tick count that triggers break under different frame configurations.

// File: rtl/uls_pkg.sv
package uls_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tag_t;

    typedef struct packed {
        logic fifo_err;
        logic tx_empty;
        logic thr_empty;
        logic brk;
        logic frm;
        logic par;
        logic ovr;
        logic dready;
    } lsr_t;

    localparam int FRAME_W = 4;

    // start + data (5..8) + optional parity + stop (1 or 2)
    function automatic logic [FRAME_W-1:0] frame_bits(input logic [1:0] wl,
                                                      input logic pen,
                                                      input logic st2);
        return FRAME_W'(7) + {2'b00, wl} + {3'b000, pen} + {3'b000, st2};
    endfunction

endpackage

// File: rtl/uls_rx_tag_fifo.sv
module uls_rx_tag_fifo
    import uls_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_tag_t       push_tag,
    input  logic          pop,
    output rx_tag_t       head_tag,
    output logic          pop_ok,
    output logic          ovr_evt,
    output logic          not_empty,
    output logic [CW-1:0] tag_cnt_q,
    output logic [CW-1:0] tag_cnt_d
);

    rx_tag_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          full, push_ok, push_tagged, pop_tagged;

    assign full        = (cnt_q == CW'(DEPTH));
    assign not_empty   = (cnt_q != '0);
    assign pop_ok      = pop && not_empty;
    assign push_ok     = push && !full;
    assign ovr_evt     = push && full;
    assign head_tag    = mem[rd_ptr];
    assign push_tagged = push_ok && (|push_tag);
    assign pop_tagged  = pop_ok && (|head_tag);

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok) cnt_d = cnt_d + CW'(1);
        if (pop_ok)  cnt_d = cnt_d - CW'(1);
        tag_cnt_d = tag_cnt_q;
        if (push_tagged) tag_cnt_d = tag_cnt_d + CW'(1);
        if (pop_tagged)  tag_cnt_d = tag_cnt_d - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            cnt_q     <= '0;
            tag_cnt_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            cnt_q     <= cnt_d;
            tag_cnt_q <= tag_cnt_d;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (push_ok && wr_ptr == AW'(i))
                    mem[i] <= push_tag;
            end
        end
    endgenerate

    p_tagcnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        tag_cnt_q <= cnt_q);

    p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (rst)
        (ovr_evt && !pop) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/uls_break_det.sv
module uls_break_det
    import uls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       baud_tick,
    input  logic [1:0] cfg_word_len,
    input  logic       cfg_par_en,
    input  logic       cfg_two_stop,
    output logic       brk_evt
);

    logic [FRAME_W-1:0] low_ticks;
    logic               fired;
    logic [FRAME_W-1:0] limit;

    assign limit   = frame_bits(cfg_word_len, cfg_par_en, cfg_two_stop);
    assign brk_evt = baud_tick && !rx_line && !fired && (low_ticks == limit);

    always_ff @(posedge clk) begin
        if (rst || rx_line) begin
            low_ticks <= '0;
            fired     <= 1'b0;
        end else if (baud_tick && !fired) begin
            if (low_ticks == limit)
                fired <= 1'b1;
            else
                low_ticks <= low_ticks + FRAME_W'(1);
        end
    end

    p_break_single_r6: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> !brk_evt);

endmodule

// File: rtl/uls_tx_status.sv
module uls_tx_status #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_push,
    input  logic tx_pop,
    input  logic tsr_idle,
    input  logic irq_en,
    output logic thr_empty,
    output logic tx_empty,
    output logic irq
);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          push_ok, pop_ok;

    assign push_ok = tx_push && (cnt_q != CW'(DEPTH));
    assign pop_ok  = tx_pop && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok) cnt_d = cnt_d + CW'(1);
        if (pop_ok)  cnt_d = cnt_d - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            thr_empty <= 1'b1;
            tx_empty  <= 1'b1;
        end else begin
            cnt_q     <= cnt_d;
            thr_empty <= (cnt_d == '0);
            tx_empty  <= (cnt_d == '0) && tsr_idle;
        end
    end

    assign irq = thr_empty && irq_en;

    p_temt_needs_thre_r9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> thr_empty);

    p_write_clears_thre_r8: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !tx_pop) |=> !thr_empty);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uls_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_char_valid,
    input  logic        rx_tag_par,
    input  logic        rx_tag_frm,
    input  logic        rx_tag_brk,
    input  logic        rx_pop,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        tsr_idle,
    input  logic        rx_line,
    input  logic        baud_tick,
    input  logic [1:0]  cfg_word_len,
    input  logic        cfg_par_en,
    input  logic        cfg_two_stop,
    input  logic        thre_irq_en,
    input  logic        stat_rd,
    output logic [31:0] status,
    output logic        thre_irq
);

    localparam int RCW = $clog2(RX_DEPTH + 1);

    rx_tag_t        in_tag, head_tag;
    logic           pop_ok, ovr_evt, not_empty, brk_evt;
    logic [RCW-1:0] tag_cnt_q, tag_cnt_d;
    logic           thr_empty, tx_empty;
    logic           par_q, frm_q, brk_q, ovr_q, err_q;
    lsr_t           lsr;

    assign in_tag = '{brk: rx_tag_brk, frm: rx_tag_frm, par: rx_tag_par};

    uls_rx_tag_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_char_valid),
        .push_tag  (in_tag),
        .pop       (rx_pop),
        .head_tag  (head_tag),
        .pop_ok    (pop_ok),
        .ovr_evt   (ovr_evt),
        .not_empty (not_empty),
        .tag_cnt_q (tag_cnt_q),
        .tag_cnt_d (tag_cnt_d)
    );

    uls_break_det u_brk (
        .clk          (clk),
        .rst          (rst),
        .rx_line      (rx_line),
        .baud_tick    (baud_tick),
        .cfg_word_len (cfg_word_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_two_stop (cfg_two_stop),
        .brk_evt      (brk_evt)
    );

    uls_tx_status #(.DEPTH(TX_DEPTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_push   (tx_push),
        .tx_pop    (tx_pop),
        .tsr_idle  (tsr_idle),
        .irq_en    (thre_irq_en),
        .thr_empty (thr_empty),
        .tx_empty  (tx_empty),
        .irq       (thre_irq)
    );

    // sticky flags: a set event in the read cycle wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
            frm_q <= 1'b0;
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            par_q <= (pop_ok && head_tag.par) || (par_q && !stat_rd);
            frm_q <= (pop_ok && head_tag.frm) || (frm_q && !stat_rd);
            brk_q <= (pop_ok && head_tag.brk) || brk_evt || (brk_q && !stat_rd);
            ovr_q <= ovr_evt || (ovr_q && !stat_rd);
            err_q <= (tag_cnt_d != '0) || (err_q && !stat_rd);
        end
    end

    always_comb begin
        lsr.fifo_err  = err_q;
        lsr.tx_empty  = tx_empty;
        lsr.thr_empty = thr_empty;
        lsr.brk       = brk_q;
        lsr.frm       = frm_q;
        lsr.par       = par_q;
        lsr.ovr       = ovr_q;
        lsr.dready    = not_empty;
        status        = {24'h0, lsr};
    end

    p_tag_shows_err_r5: assert property (@(posedge clk) disable iff (rst)
        (tag_cnt_q != '0) |-> status[7]);

    p_par_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (par_q && !stat_rd) |=> par_q);

    p_frm_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (frm_q && !stat_rd) |=> frm_q);

    p_irq_follows_thre_r10: assert property (@(posedge clk) disable iff (rst)
        thre_irq |-> status[5]);

endmodule

// File: tb/uart_line_status_test.sv
module uart_line_status_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_char_valid, rx_tag_par, rx_tag_frm, rx_tag_brk, rx_pop;
    logic        tx_push, tx_pop, tsr_idle, rx_line, baud_tick;
    logic [1:0]  cfg_word_len;
    logic        cfg_par_en, cfg_two_stop, thre_irq_en, stat_rd;
    logic [31:0] status;
    logic        thre_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_line_status uut (
        .clk(clk), .rst(rst),
        .rx_char_valid(rx_char_valid), .rx_tag_par(rx_tag_par),
        .rx_tag_frm(rx_tag_frm), .rx_tag_brk(rx_tag_brk), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_pop(tx_pop), .tsr_idle(tsr_idle),
        .rx_line(rx_line), .baud_tick(baud_tick),
        .cfg_word_len(cfg_word_len), .cfg_par_en(cfg_par_en),
        .cfg_two_stop(cfg_two_stop), .thre_irq_en(thre_irq_en),
        .stat_rd(stat_rd), .status(status), .thre_irq(thre_irq)
    );

    // control field order: valid par frm brk pop tpush tpop idle rd
    localparam int NV = 25;
    localparam logic [16:0] VEC [NV] = '{
        {9'b1_000_0_00_1_0, 8'h61},  // R2 clean push
        {9'b1_100_0_00_1_0, 8'hE1},  // R5 parity-tagged push
        {9'b1_000_0_00_1_0, 8'hE1},
        {9'b1_010_0_00_1_0, 8'hE1},  // framing-tagged, FIFO now full
        {9'b1_000_0_00_1_0, 8'hE3},  // R3 overrun
        {9'b0_000_0_00_1_1, 8'hE1},  // R7 read, R5 tags remain
        {9'b0_000_1_00_1_0, 8'hE1},
        {9'b0_000_1_00_1_0, 8'hE5},  // R4 parity popped
        {9'b0_000_1_00_1_0, 8'hE5},
        {9'b0_000_1_00_1_0, 8'hEC},  // R4 framing popped, R5 held
        {9'b0_000_0_00_1_1, 8'h60},  // R7 read clears all
        {9'b0_000_0_10_1_0, 8'h00},  // R8 write
        {9'b0_000_0_10_1_0, 8'h00},
        {9'b0_000_0_01_0_0, 8'h00},
        {9'b0_000_0_01_0_0, 8'h20},  // R8 last word moved, R9 shift busy
        {9'b0_000_0_00_1_0, 8'h60},  // R9 idle
        {9'b0_000_0_11_1_0, 8'h00},  // pop on empty ignored
        {9'b0_000_0_11_1_0, 8'h00},
        {9'b0_000_0_01_1_0, 8'h60},
        {9'b1_001_0_00_1_0, 8'hE1},  // break-tagged push
        {9'b0_000_1_00_1_1, 8'h70},  // R7 set wins, R5 cleared
        {9'b0_000_0_00_1_1, 8'h60},
        {9'b1_100_0_00_1_1, 8'hE1},  // R5 push in read cycle
        {9'b0_000_1_00_1_0, 8'hE4},
        {9'b0_000_0_00_1_1, 8'h60}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_char_valid = 0; rx_tag_par = 0; rx_tag_frm = 0; rx_tag_brk = 0;
        rx_pop = 0; tx_push = 0; tx_pop = 0; tsr_idle = 1;
        baud_tick = 0; stat_rd = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        baud_tick = 1;
        cyc();
        baud_tick = 0;
        cyc();
    endtask

    task automatic read_status();
        stat_rd = 1;
        cyc();
        stat_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rx_line = 1; cfg_word_len = 2'd3; cfg_par_en = 1; cfg_two_stop = 0;
        thre_irq_en = 1; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        cyc();
        check("R1 reset status", status, 32'h60);
        check("R10 irq after reset", {31'b0, thre_irq}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            {rx_char_valid, rx_tag_par, rx_tag_frm, rx_tag_brk, rx_pop,
             tx_push, tx_pop, tsr_idle, stat_rd} = VEC[i][16:8];
            cyc();
            check($sformatf("R2-vector %0d status", i), status, {24'h0, VEC[i][7:0]});
            check($sformatf("R10 vector %0d irq", i), {31'b0, thre_irq}, {31'b0, VEC[i][5]});
            idle_inputs();
        end

        // R10 gating
        thre_irq_en = 0;
        cyc();
        check("R10 irq masked", {31'b0, thre_irq}, 32'h0);
        check("R8 thre still set", {31'b0, status[5]}, 32'h1);
        thre_irq_en = 1;

        // R6 break: 8 data, parity, 1 stop -> frame 11
        rx_line = 0;
        for (int k = 0; k < 11; k++) tick();
        check("R6 no break at frame", status, 32'h60);
        tick();
        check("R6 break after frame", status, 32'h70);
        read_status();
        check("R7 break cleared by read", status, 32'h60);
        for (int k = 0; k < 5; k++) tick();
        check("R6 single break per low", status, 32'h60);
        rx_line = 1;
        cyc();

        // R6 break: 5 data, no parity, 2 stop -> frame 8
        cfg_word_len = 2'd0; cfg_par_en = 0; cfg_two_stop = 1;
        rx_line = 0;
        for (int k = 0; k < 8; k++) tick();
        check("R6 short frame not yet", status, 32'h60);
        tick();
        check("R6 short frame break", status, 32'h70);
        rx_line = 1;
        cyc();
        read_status();
        check("R11 upper bits zero", {24'h0, status[31:8]}, 32'h0);

        // R1 reset from a busy state
        tx_push = 1;
        rx_char_valid = 1; rx_tag_frm = 1;
        cyc();
        idle_inputs();
        check("R9 busy before reset", status, 32'h81);
        rst = 1;
        cyc();
        rst = 0;
        check("R1 reset clears busy state", status, 32'h60);

        finish_run();
    end

endmodule